// File: doc/BRIEF.md
# Dual-Channel Step Attenuator Control Core

This block is the digital control core of a two-channel step attenuator. One channel is the main path and the other is the diversity path. Each channel gets a 6-bit attenuation code with a step of 0.25 dB. The block keeps a small set of configuration registers, which a register-write port loads. The serial framing in front of that port is outside this block.

For each channel, a mode bit picks the source of the code. In pin mode, a select pin switches between zero attenuation and a programmed value, and a disable pin turns the channel off. In register mode, the code comes from a dedicated attenuation register, and both pins are ignored. When the diversity channel is in register mode, its select pad is turned into a general-purpose output, and a configuration bit sets its level.

Every output is registered, so a mode change or a register write never produces a glitch.

Top module: `atten_ctrl_core`

## Requirements
- R1: While reset is asserted, both codes are 0, both enables are 1, `gpo_o` is 0 and `gpo_oe_o` is 0. Both channels reset to pin mode. The pin-mode values reset to 0x3C (15 dB) and the register-mode values reset to 0x00.
- R2: In pin mode, with the disable pin low and the select pin low, the channel's code is 0 and its enable is 1.
- R3: In pin mode, with the disable pin low and the select pin high, the channel's code is its pin-mode value. That value is held at address 0x16 for main and 0x17 for diversity.
- R4: In pin mode, a high disable pin forces the code to 0x3F and the enable to 0, whatever the select pin does.
- R5: When bit 2 of address 0x13 is 1, the main code equals the register at address 0x11 and the main enable is 1. Both main pins are ignored.
- R6: When bit 1 of address 0x13 is 1, the diversity code equals the register at address 0x12 and the diversity enable is 1. Both diversity pins are ignored.
- R7: `gpo_oe_o` equals bit 1 of address 0x13. `gpo_o` equals bit 5 of address 0x13 while `gpo_oe_o` is 1, and is 0 otherwise.
- R8: Writes to the pin-mode values take effect while the channel is in pin mode.
- R9: A write to any address other than 0x11, 0x12, 0x13, 0x16 or 0x17 changes no output. Bits of address 0x13 other than 1, 2 and 5 have no effect on any output.
- R10: A pin change is seen at the outputs on the first rising edge after it. A write on edge k is seen at the outputs on edge k+1 and not on edge k.
- R11: Only data bits [5:0] are stored in an attenuation register. Bits [7:6] of the written byte are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_sel_i | input | 1 | Main select pin: zero or programmed value |
| main_dis_i | input | 1 | Main disable pin |
| div_sel_i | input | 1 | Diversity select pin, read from the pad in pin mode |
| div_dis_i | input | 1 | Diversity disable pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| main_code_o | output | 6 | Main attenuation code |
| div_code_o | output | 6 | Diversity attenuation code |
| main_en_o | output | 1 | Main channel enable |
| div_en_o | output | 1 | Diversity channel enable |
| gpo_o | output | 1 | General-purpose output level for the diversity select pad |
| gpo_oe_o | output | 1 | Output enable for the diversity select pad |

## Verification
The assertions assume that the pins and the write port change only away from the rising clock edge. They also assume that each input holds its value for at least one full cycle, so that a one-cycle look-back pairs each output with the inputs that caused it.

The bench follows these assumptions. It drives every input on the falling edge and keeps each write strobe high for exactly one cycle. Pins are never moved in the same cycle as a write, so every output value can be traced to a single cause.

// File: rtl/atten_pkg.sv
package atten_pkg;
   localparam int NUM_CH  = 2;
   localparam int CH_MAIN = 0;
   localparam int CH_DIV  = 1;

   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,
      SRC_PIN  = 2'd1,
      SRC_REG  = 2'd2,
      SRC_OFF  = 2'd3
   } atten_src_e;
endpackage

// File: rtl/atten_regfile.sv
module atten_regfile
   import atten_pkg::*;
#(
   parameter int CODE_W = 6,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] A_MAIN_REG = 8'h11,
   parameter logic [ADDR_W-1:0] A_DIV_REG  = 8'h12,
   parameter logic [ADDR_W-1:0] A_CFG      = 8'h13,
   parameter logic [ADDR_W-1:0] A_MAIN_PIN = 8'h16,
   parameter logic [ADDR_W-1:0] A_DIV_PIN  = 8'h17,
   parameter int PIN_RST = 60,
   parameter int REG_RST = 0,
   parameter int MAIN_MODE_BIT = 2,
   parameter int DIV_MODE_BIT  = 1,
   parameter int GPO_BIT       = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [NUM_CH-1:0][CODE_W-1:0] reg_code,
   output logic [NUM_CH-1:0][CODE_W-1:0] pin_code,
   output logic [NUM_CH-1:0]             reg_mode,
   output logic                          gpo_lvl
);
   localparam logic [NUM_CH-1:0][ADDR_W-1:0] REG_ADDR = {A_DIV_REG, A_MAIN_REG};
   localparam logic [NUM_CH-1:0][ADDR_W-1:0] PIN_ADDR = {A_DIV_PIN, A_MAIN_PIN};
   localparam int MODE_BIT [NUM_CH] = '{MAIN_MODE_BIT, DIV_MODE_BIT};
   localparam logic [CODE_W-1:0] PIN_RST_C = CODE_W'(PIN_RST);
   localparam logic [CODE_W-1:0] REG_RST_C = CODE_W'(REG_RST);

   logic cfg_hit;
   assign cfg_hit = wr_en && (wr_addr == A_CFG);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic reg_hit, pin_hit;
      assign reg_hit = wr_en && (wr_addr == REG_ADDR[ch]);
      assign pin_hit = wr_en && (wr_addr == PIN_ADDR[ch]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            reg_code[ch] <= REG_RST_C;
            pin_code[ch] <= PIN_RST_C;
            reg_mode[ch] <= 1'b0;
         end else begin
            if (reg_hit) reg_code[ch] <= wr_data[CODE_W-1:0];
            if (pin_hit) pin_code[ch] <= wr_data[CODE_W-1:0];
            if (cfg_hit) reg_mode[ch] <= wr_data[MODE_BIT[ch]];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gpo_lvl <= 1'b0;
      else if (cfg_hit) gpo_lvl <= wr_data[GPO_BIT];
   end
endmodule

// File: rtl/atten_chan_path.sv
module atten_chan_path
   import atten_pkg::*;
#(
   parameter int CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_mode,
   input  logic              sel_pin,
   input  logic              dis_pin,
   input  logic [CODE_W-1:0] pin_code,
   input  logic [CODE_W-1:0] reg_code,
   output logic [CODE_W-1:0] code_q,
   output logic              en_q
);
   localparam logic [CODE_W-1:0] CODE_MAX = '1;

   atten_src_e        src;
   logic [CODE_W-1:0] code_nxt;

   always_comb begin
      if (reg_mode)     src = SRC_REG;
      else if (dis_pin) src = SRC_OFF;
      else if (sel_pin) src = SRC_PIN;
      else              src = SRC_ZERO;
   end

   always_comb begin
      unique case (src)
         SRC_REG:  code_nxt = reg_code;
         SRC_OFF:  code_nxt = CODE_MAX;
         SRC_PIN:  code_nxt = pin_code;
         default:  code_nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         en_q   <= 1'b1;
      end else begin
         code_q <= code_nxt;
         en_q   <= (src != SRC_OFF);
      end
   end
endmodule

// File: rtl/atten_gpo_drv.sv
module atten_gpo_drv (
   input  logic clk,
   input  logic rst_n,
   input  logic div_reg_mode,
   input  logic gpo_lvl,
   output logic gpo_q,
   output logic gpo_oe_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gpo_q    <= 1'b0;
         gpo_oe_q <= 1'b0;
      end else begin
         gpo_oe_q <= div_reg_mode;
         gpo_q    <= div_reg_mode & gpo_lvl;
      end
   end
endmodule

// File: rtl/atten_ctrl_core.sv
module atten_ctrl_core
   import atten_pkg::*;
#(
   parameter int CODE_W = 6,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] A_MAIN_REG = 8'h11,
   parameter logic [ADDR_W-1:0] A_DIV_REG  = 8'h12,
   parameter logic [ADDR_W-1:0] A_CFG      = 8'h13,
   parameter logic [ADDR_W-1:0] A_MAIN_PIN = 8'h16,
   parameter logic [ADDR_W-1:0] A_DIV_PIN  = 8'h17,
   parameter int PIN_RST = 60,
   parameter int REG_RST = 0,
   parameter int MAIN_MODE_BIT = 2,
   parameter int DIV_MODE_BIT  = 1,
   parameter int GPO_BIT       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              main_sel_i,
   input  logic              main_dis_i,
   input  logic              div_sel_i,
   input  logic              div_dis_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [CODE_W-1:0] main_code_o,
   output logic [CODE_W-1:0] div_code_o,
   output logic              main_en_o,
   output logic              div_en_o,
   output logic              gpo_o,
   output logic              gpo_oe_o
);
   if (CODE_W > DATA_W) begin : g_chk_width
      $error("attenuation code wider than write data");
   end
   if (MAIN_MODE_BIT >= DATA_W || DIV_MODE_BIT >= DATA_W || GPO_BIT >= DATA_W) begin : g_chk_bits
      $error("configuration bit outside write data");
   end
   if (MAIN_MODE_BIT == DIV_MODE_BIT || GPO_BIT == MAIN_MODE_BIT || GPO_BIT == DIV_MODE_BIT) begin : g_chk_overlap
      $error("configuration bits overlap");
   end
   if (PIN_RST >= (1 << CODE_W) || REG_RST >= (1 << CODE_W)) begin : g_chk_rst
      $error("reset code does not fit the code width");
   end

   logic [NUM_CH-1:0]             sel_vec, dis_vec, reg_mode, en_q;
   logic [NUM_CH-1:0][CODE_W-1:0] reg_code, pin_code, code_q;
   logic                          gpo_lvl;

   assign sel_vec = {div_sel_i, main_sel_i};
   assign dis_vec = {div_dis_i, main_dis_i};

   atten_regfile #(
      .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .A_MAIN_REG(A_MAIN_REG), .A_DIV_REG(A_DIV_REG), .A_CFG(A_CFG),
      .A_MAIN_PIN(A_MAIN_PIN), .A_DIV_PIN(A_DIV_PIN),
      .PIN_RST(PIN_RST), .REG_RST(REG_RST),
      .MAIN_MODE_BIT(MAIN_MODE_BIT), .DIV_MODE_BIT(DIV_MODE_BIT), .GPO_BIT(GPO_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
      .reg_code(reg_code), .pin_code(pin_code),
      .reg_mode(reg_mode), .gpo_lvl(gpo_lvl)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_path
      atten_chan_path #(.CODE_W(CODE_W)) u_path (
         .clk(clk), .rst_n(rst_n),
         .reg_mode(reg_mode[ch]), .sel_pin(sel_vec[ch]), .dis_pin(dis_vec[ch]),
         .pin_code(pin_code[ch]), .reg_code(reg_code[ch]),
         .code_q(code_q[ch]), .en_q(en_q[ch])
      );
   end

   atten_gpo_drv u_gpo (
      .clk(clk), .rst_n(rst_n),
      .div_reg_mode(reg_mode[CH_DIV]), .gpo_lvl(gpo_lvl),
      .gpo_q(gpo_o), .gpo_oe_q(gpo_oe_o)
   );

   assign main_code_o = code_q[CH_MAIN];
   assign div_code_o  = code_q[CH_DIV];
   assign main_en_o   = en_q[CH_MAIN];
   assign div_en_o    = en_q[CH_DIV];
endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk #(
   parameter int CODE_W = 6
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [1:0]             sel_vec,
   input logic [1:0]             dis_vec,
   input logic [1:0]             reg_mode,
   input logic [1:0][CODE_W-1:0] reg_code,
   input logic [1:0][CODE_W-1:0] pin_code,
   input logic [CODE_W-1:0]      main_code_o,
   input logic [CODE_W-1:0]      div_code_o,
   input logic                   main_en_o,
   input logic                   div_en_o,
   input logic                   gpo_o,
   input logic                   gpo_oe_o
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R2
   a_r2_main_zero: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(!reg_mode[0] && !dis_vec[0] && !sel_vec[0]) |-> main_code_o == '0 && main_en_o);
   // R3
   a_r3_main_pin_value: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(!reg_mode[0] && !dis_vec[0] && sel_vec[0]) |-> main_code_o == $past(pin_code[0]));
   a_r3_div_pin_value: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(!reg_mode[1] && !dis_vec[1] && sel_vec[1]) |-> div_code_o == $past(pin_code[1]));
   // R4
   a_r4_main_off: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(!reg_mode[0] && dis_vec[0]) |-> main_code_o == '1 && !main_en_o);
   a_r4_div_off: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(!reg_mode[1] && dis_vec[1]) |-> div_code_o == '1 && !div_en_o);
   // R5
   a_r5_main_reg: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(reg_mode[0]) |-> main_code_o == $past(reg_code[0]) && main_en_o);
   // R6
   a_r6_div_reg: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(reg_mode[1]) |-> div_code_o == $past(reg_code[1]) && div_en_o);
   // R7
   a_r7_oe_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> gpo_oe_o == $past(reg_mode[1]));
   a_r7_gpo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !gpo_oe_o |-> !gpo_o);
endmodule

bind atten_ctrl_core atten_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .sel_vec(sel_vec), .dis_vec(dis_vec), .reg_mode(reg_mode),
   .reg_code(reg_code), .pin_code(pin_code),
   .main_code_o(main_code_o), .div_code_o(div_code_o),
   .main_en_o(main_en_o), .div_en_o(div_en_o),
   .gpo_o(gpo_o), .gpo_oe_o(gpo_oe_o)
);

// File: tb/test_atten_ctrl_core.sv
`timescale 1ns/1ps
module test_atten_ctrl_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       main_sel = 0, main_dis = 0, div_sel = 0, div_dis = 0;
   logic       wr_en = 0;
   logic [7:0] wr_addr = '0, wr_data = '0;
   logic [5:0] main_code, div_code;
   logic       main_en, div_en, gpo, gpo_oe;

   always #4 clk = ~clk;

   atten_ctrl_core i_atten_ctrl_core (
      .clk(clk), .rst_n(rst_n),
      .main_sel_i(main_sel), .main_dis_i(main_dis),
      .div_sel_i(div_sel), .div_dis_i(div_dis),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .main_code_o(main_code), .div_code_o(div_code),
      .main_en_o(main_en), .div_en_o(div_en),
      .gpo_o(gpo), .gpo_oe_o(gpo_oe)
   );

   typedef struct {
      logic [5:0] mc, dc;
      logic       me, de, g, oe;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0, errors = 0;

   // bench-side register model, written from the requirements
   logic [5:0] m_main_reg = 6'h00, m_div_reg = 6'h00;
   logic [5:0] m_main_pin = 6'h3C, m_div_pin = 6'h3C;
   logic       m_main_mode = 0, m_div_mode = 0, m_gpo = 0;

   function automatic exp_t predict(string tag);
      exp_t e;
      e.tag = tag;
      if (m_main_mode)   begin e.mc = m_main_reg; e.me = 1; end
      else if (main_dis) begin e.mc = 6'h3F;      e.me = 0; end
      else if (main_sel) begin e.mc = m_main_pin; e.me = 1; end
      else               begin e.mc = 6'h00;      e.me = 1; end
      if (m_div_mode)    begin e.dc = m_div_reg;  e.de = 1; end
      else if (div_dis)  begin e.dc = 6'h3F;      e.de = 0; end
      else if (div_sel)  begin e.dc = m_div_pin;  e.de = 1; end
      else               begin e.dc = 6'h00;      e.de = 1; end
      e.oe = m_div_mode;
      e.g  = m_div_mode & m_gpo;
      return e;
   endfunction

   task automatic compare(exp_t e);
      checks++;
      if (main_code !== e.mc || div_code !== e.dc || main_en !== e.me ||
          div_en !== e.de || gpo !== e.g || gpo_oe !== e.oe) begin
         errors++;
         $display("FAIL %s: got mc=%h dc=%h me=%b de=%b g=%b oe=%b exp mc=%h dc=%h me=%b de=%b g=%b oe=%b",
                  e.tag, main_code, div_code, main_en, div_en, gpo, gpo_oe,
                  e.mc, e.dc, e.me, e.de, e.g, e.oe);
      end
   endtask

   // monitor: compares queued expectations away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) compare(q.pop_front());
      end
   end

   // apply pins, expect the result on the very next edge (R10 latency)
   task automatic pins(logic ms, logic md, logic ds, logic dd, string tag);
      @(negedge clk);
      main_sel = ms; main_dis = md; div_sel = ds; div_dis = dd;
      @(posedge clk);
      q.push_back(predict(tag));
   endtask

   // one-cycle write; on the write edge the outputs still show the old state (R10)
   task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(posedge clk);
      q.push_back(predict({"R10 old value on write edge / ", tag}));
      case (a)
         8'h11: m_main_reg = d[5:0];
         8'h12: m_div_reg  = d[5:0];
         8'h13: begin m_div_mode = d[1]; m_main_mode = d[2]; m_gpo = d[5]; end
         8'h16: m_main_pin = d[5:0];
         8'h17: m_div_pin  = d[5:0];
         default: ;
      endcase
      @(negedge clk);
      wr_en = 0;
      @(posedge clk);
      q.push_back(predict(tag));
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      exp_t r;
      repeat (3) @(negedge clk);
      // R1 reset state
      r.mc = 0; r.dc = 0; r.me = 1; r.de = 1; r.g = 0; r.oe = 0; r.tag = "R1 reset";
      compare(r);
      @(negedge clk);
      rst_n = 1;

      pins(0, 0, 0, 0, "R2 both select low");
      pins(1, 0, 1, 0, "R3 default pin value 0x3C");
      pins(1, 1, 0, 1, "R4 disable forces 0x3F");
      pins(0, 1, 1, 1, "R4 disable over select");
      pins(1, 0, 1, 0, "R3 back to pin value");
      wr(8'h16, 8'h15, "R8 main pin value rewrite");
      wr(8'h17, 8'h2A, "R8 div pin value rewrite");
      wr(8'h16, 8'hC7, "R11 upper data bits dropped");
      wr(8'h20, 8'hFF, "R9 undefined address");
      wr(8'h15, 8'h00, "R9 undefined address near map");
      wr(8'h13, 8'hD9, "R9 unused config bits");
      wr(8'h11, 8'h2B, "R5 main reg value staged");
      wr(8'h13, 8'h04, "R5 main reg mode");
      pins(0, 1, 1, 0, "R5 main pins ignored");
      wr(8'h12, 8'h51, "R6 div reg value staged");
      wr(8'h13, 8'h06, "R6 div reg mode, R7 oe on");
      pins(1, 0, 0, 1, "R6 div pins ignored");
      wr(8'h13, 8'h26, "R7 gpo level high");
      wr(8'h13, 8'h20, "R7 oe off, level masked");
      pins(1, 0, 1, 0, "R3 pin mode restored");
      wr(8'h13, 8'h00, "R7 cleared config");

      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule